// File: doc/BRIEF.md
# DMA Address and Count Engine

This block keeps, for each of several DMA channels, a base and a current memory offset, a base and a current item count, a page value and an 8-bit mode word. For whichever channel the arbiter has granted, it presents the full memory address as the page value joined to the 16-bit current offset. It also reports the data direction of that channel and whether the channel should keep the bus. Each pulse of the transfer-done strobe steps the granted channel's offset up or down and counts its remaining items down by one.

When the count runs out, the block flags end of process in the same cycle as the final strobe and sets that channel's sticky terminal-count bit. Then it either reloads the channel from its base values, if auto-initialization is on, or masks the channel so that later strobes on it have no effect. A load port writes one channel's page, offset, count and mode in one cycle. The load clears that channel's mask and terminal-count bits. The arbiter and the register decoding sit outside this block.

Top module: `dma_addr_engine`

## Requirements
- R1: `memAddr` shows the granted channel's page value in bits 19:16 and its current offset in bits 15:0. A load writes the page, and writes the given offset and count into both the base and the current registers of `loadCh`, effective from the next cycle.
- R2: Stepping never changes the page bits. An offset of 0xFFFF that increments becomes 0x0000, and 0x0000 that decrements becomes 0xFFFF, both within the same page.
- R3: With mode bit 5 = 1 the offset rises by one per accepted transfer. With bit 5 = 0 it falls by one.
- R4: Each accepted transfer decrements the count. A transfer accepted while the count is 0x0000 drives `eop` high in that same cycle, so a count of N moves N+1 items. From the next cycle, `tcStatus[ch]` is 1.
- R5: With mode bit 4 = 1, the terminal transfer reloads the current offset and count from the base values and leaves the mask bit clear.
- R6: With mode bit 4 = 0, the terminal transfer sets `maskOut[ch]`. A strobe on a masked channel is ignored: no `eop`, and offset and count are unchanged.
- R7: Mode bits 3:2 give the direction for the granted channel. 01 drives `memWr`, 10 drives `memRd`, and 00 (verify) drives neither while the offset and count still step. `memRd` and `memWr` are never both 1.
- R8: Mode bits 7:6 give the service mode. `keepBus` is `dreq` in demand mode (00), 0 in single mode (01), and 1 in block mode (10), in each case only while the count is not 0x0000 and the channel is unmasked. Cascade mode (11) gives `keepBus` = 0, no direction strobes, and no stepping or `eop`.
- R9: Reset leaves every channel masked, every terminal-count bit clear, and every offset, count and page at zero. A load clears the mask and terminal-count bits of its channel.
- R10: A load to the granted channel in the same cycle as its strobe takes precedence. The strobe is not counted: there is no `eop` and no terminal-count bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Load one channel's settings this cycle |
| loadCh | input | CH_W | Channel to load |
| loadMode | input | 8 | Mode word for the loaded channel |
| loadPage | input | PAGE_W | Page value for the loaded channel |
| loadAddr | input | OFS_W | Start offset (base and current) |
| loadCount | input | OFS_W | Item count minus one (base and current) |
| grantCh | input | CH_W | Channel currently granted the bus |
| xferDone | input | 1 | One transfer of the granted channel completes this cycle |
| dreq | input | 1 | Request level of the granted channel (demand mode) |
| memAddr | output | PAGE_W+OFS_W | Memory address of the granted channel |
| memRd | output | 1 | Granted channel reads memory |
| memWr | output | 1 | Granted channel writes memory |
| eop | output | 1 | Terminal transfer in this cycle |
| keepBus | output | 1 | Granted channel wants to hold the bus |
| tcStatus | output | NUM_CH | Sticky terminal-count bits, one per channel |
| maskOut | output | NUM_CH | Channel mask bits |

## Verification
Two functions can fall in one cycle. The first pair is a transfer strobe and a load to the same channel. The bench provokes this when the granted channel's count is already zero, so a wrong priority would show up as an `eop` and a set terminal-count bit. The second pair is terminal count and the auto-initialization reload, which happen on a single strobe. The bench judges the address on the next cycle, which must equal the base offset and not the stepped one. A reference model in the bench predicts the address and `eop` for every strobe, and a monitor compares them in the strobe's own cycle.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int MODE_W = 8;

  typedef enum logic [1:0] {
    SVC_DEMAND  = 2'b00,
    SVC_SINGLE  = 2'b01,
    SVC_BLOCK   = 2'b10,
    SVC_CASCADE = 2'b11
  } svcMode_e;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'b00,
    XF_WRITE  = 2'b01,
    XF_READ   = 2'b10,
    XF_NONE   = 2'b11
  } xferType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic reload;
    logic countUp;
  } dpCmd_t;
endpackage

// File: rtl/dma_eng_ctrl.sv
module dma_eng_ctrl
  import dma_eng_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [CH_W-1:0]   loadCh,
  input  logic [MODE_W-1:0] loadMode,
  input  logic [CH_W-1:0]   grantCh,
  input  logic              xferDone,
  input  logic              dreq,
  input  logic              cntZero,
  output dpCmd_t            cmd,
  output logic              memRd,
  output logic              memWr,
  output logic              eop,
  output logic              keepBus,
  output logic [NUM_CH-1:0] tcStatus,
  output logic [NUM_CH-1:0] maskOut
);
  logic [NUM_CH-1:0][MODE_W-1:0] modeReg;
  logic [NUM_CH-1:0] maskReg, tcReg, loadHit, termHitCh;
  logic [MODE_W-1:0] grantMode;
  svcMode_e  svc;
  xferType_e xType;
  logic loadHitsGrant, active, termHit, grantMasked;

  assign grantMode     = modeReg[grantCh];
  assign svc           = svcMode_e'(grantMode[7:6]);
  assign xType         = xferType_e'(grantMode[3:2]);
  assign grantMasked   = maskReg[grantCh];
  assign loadHitsGrant = loadEn && (loadCh == grantCh);
  assign active        = xferDone && !grantMasked && (svc != SVC_CASCADE) && !loadHitsGrant;
  assign termHit       = active && cntZero;

  always_comb begin
    cmd.load    = loadEn;
    cmd.step    = active;
    cmd.reload  = termHit && grantMode[4];
    cmd.countUp = grantMode[5];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign loadHit[i]   = loadEn && (loadCh == CH_W'(i));
    assign termHitCh[i] = termHit && (grantCh == CH_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (!rstN) begin
        modeReg[i] <= '0;
        maskReg[i] <= 1'b1;
        tcReg[i]   <= 1'b0;
      end else if (loadHit[i]) begin
        modeReg[i] <= loadMode;
        maskReg[i] <= 1'b0;
        tcReg[i]   <= 1'b0;
      end else if (termHitCh[i]) begin
        tcReg[i] <= 1'b1;
        if (!grantMode[4]) maskReg[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (svc)
      SVC_DEMAND: keepBus = dreq && !cntZero && !grantMasked;
      SVC_BLOCK:  keepBus = !cntZero && !grantMasked;
      default:    keepBus = 1'b0;
    endcase
  end

  assign memWr    = (svc != SVC_CASCADE) && (xType == XF_WRITE);
  assign memRd    = (svc != SVC_CASCADE) && (xType == XF_READ);
  assign eop      = termHit;
  assign tcStatus = tcReg;
  assign maskOut  = maskReg;
endmodule

// File: rtl/dma_eng_dpath.sv
module dma_eng_dpath
  import dma_eng_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 4,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [CH_W-1:0]   loadCh,
  input  logic [PAGE_W-1:0] loadPage,
  input  logic [OFS_W-1:0]  loadAddr,
  input  logic [OFS_W-1:0]  loadCount,
  input  logic [CH_W-1:0]   grantCh,
  output logic [ADDR_W-1:0] memAddr,
  output logic              cntZero
);
  logic [NUM_CH-1:0][OFS_W-1:0]  baseAddr, baseCnt, curAddr, curCnt;
  logic [NUM_CH-1:0][PAGE_W-1:0] pageReg;
  logic [NUM_CH-1:0] loadHit, stepHit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign loadHit[i] = cmd.load && (loadCh == CH_W'(i));
    assign stepHit[i] = cmd.step && (grantCh == CH_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (!rstN) begin
        baseAddr[i] <= '0;
        baseCnt[i]  <= '0;
        curAddr[i]  <= '0;
        curCnt[i]   <= '0;
        pageReg[i]  <= '0;
      end else if (loadHit[i]) begin
        baseAddr[i] <= loadAddr;
        baseCnt[i]  <= loadCount;
        curAddr[i]  <= loadAddr;
        curCnt[i]   <= loadCount;
        pageReg[i]  <= loadPage;
      end else if (stepHit[i]) begin
        if (cmd.reload) begin
          curAddr[i] <= baseAddr[i];
          curCnt[i]  <= baseCnt[i];
        end else begin
          // offset wraps inside its page: no carry reaches pageReg
          curAddr[i] <= cmd.countUp ? curAddr[i] + 1'b1 : curAddr[i] - 1'b1;
          curCnt[i]  <= curCnt[i] - 1'b1;
        end
      end
    end
  end

  assign memAddr = {pageReg[grantCh], curAddr[grantCh]};
  assign cntZero = (curCnt[grantCh] == '0);
endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
  import dma_eng_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 4,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [CH_W-1:0]   loadCh,
  input  logic [7:0]        loadMode,
  input  logic [PAGE_W-1:0] loadPage,
  input  logic [OFS_W-1:0]  loadAddr,
  input  logic [OFS_W-1:0]  loadCount,
  input  logic [CH_W-1:0]   grantCh,
  input  logic              xferDone,
  input  logic              dreq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic              eop,
  output logic              keepBus,
  output logic [NUM_CH-1:0] tcStatus,
  output logic [NUM_CH-1:0] maskOut
);
  dpCmd_t cmd;
  logic   cntZero;

  dma_eng_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadCh(loadCh), .loadMode(loadMode),
    .grantCh(grantCh), .xferDone(xferDone), .dreq(dreq), .cntZero(cntZero),
    .cmd(cmd), .memRd(memRd), .memWr(memWr), .eop(eop), .keepBus(keepBus),
    .tcStatus(tcStatus), .maskOut(maskOut)
  );

  dma_eng_dpath #(.NUM_CH(NUM_CH), .OFS_W(OFS_W), .PAGE_W(PAGE_W), .CH_W(CH_W),
                  .ADDR_W(ADDR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadCh(loadCh), .loadPage(loadPage),
    .loadAddr(loadAddr), .loadCount(loadCount), .grantCh(grantCh),
    .memAddr(memAddr), .cntZero(cntZero)
  );
endmodule

// File: rtl/dma_eng_checker.sv
module dma_eng_checker #(
  parameter int NUM_CH = 4,
  parameter int OFS_W  = 16,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic [CH_W-1:0]   grantCh,
  input logic              xferDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic              memWr,
  input logic              eop,
  input logic [NUM_CH-1:0] tcStatus,
  input logic [NUM_CH-1:0] maskOut
);
  assert_eop_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    eop |-> xferDone);

  assert_tc_after_eop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (eop && !loadEn) |=> tcStatus[$past(grantCh)]);

  assert_dir_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !loadEn) |=> (grantCh != $past(grantCh)) ||
      (memAddr[ADDR_W-1:OFS_W] == $past(memAddr[ADDR_W-1:OFS_W])));

  assert_mask_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> (($past(maskOut) & ~maskOut) == '0));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    maskOut[grantCh] |-> !eop);
endmodule

bind dma_addr_engine dma_eng_checker #(.NUM_CH(NUM_CH), .OFS_W(OFS_W), .CH_W(CH_W),
                                       .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .grantCh(grantCh), .xferDone(xferDone),
  .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .eop(eop),
  .tcStatus(tcStatus), .maskOut(maskOut)
);

// File: tb/test_dma_addr_engine.sv
module test_dma_addr_engine;
  logic        clk = 0, rstN = 0;
  logic        loadEn = 0, xferDone = 0, dreq = 0;
  logic [1:0]  loadCh = 0, grantCh = 0;
  logic [7:0]  loadMode = 0;
  logic [3:0]  loadPage = 0;
  logic [15:0] loadAddr = 0, loadCount = 0;
  logic [19:0] memAddr;
  logic        memRd, memWr, eop, keepBus;
  logic [3:0]  tcStatus, maskOut;

  int checks = 0, fails = 0;
  logic [20:0] expQ[$];   // {eop, addr}

  // reference model
  logic [15:0] mCur[4], mCnt[4], mBase[4], mBCnt[4];
  logic [3:0]  mPage[4];
  logic [7:0]  mMode[4];

  always #2.5 clk = ~clk;

  dma_addr_engine i_dma_addr_engine (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [1:0] ch, input logic [7:0] md, input logic [3:0] pg,
                        input logic [15:0] ad, input logic [15:0] cn);
    loadEn = 1; loadCh = ch; loadMode = md; loadPage = pg; loadAddr = ad; loadCount = cn;
    @(posedge clk); #1 loadEn = 0;
    mCur[ch] = ad; mBase[ch] = ad; mCnt[ch] = cn; mBCnt[ch] = cn; mPage[ch] = pg; mMode[ch] = md;
  endtask

  // driver: one transfer strobe, pushes expected item, updates the model
  task automatic doXfer(input logic [1:0] ch, input logic masked);
    logic act, e;
    act = !masked && (mMode[ch][7:6] != 2'b11);
    e   = act && (mCnt[ch] == 16'h0);
    expQ.push_back({e, mPage[ch], mCur[ch]});
    grantCh = ch; xferDone = 1;
    @(posedge clk); #1 xferDone = 0;
    if (act) begin
      if (e && mMode[ch][4]) begin
        mCur[ch] = mBase[ch]; mCnt[ch] = mBCnt[ch];
      end else begin
        mCur[ch] = mMode[ch][5] ? mCur[ch] + 16'h1 : mCur[ch] - 16'h1;
        mCnt[ch] = mCnt[ch] - 16'h1;
      end
    end
  endtask

  // monitor: compares each strobe cycle against the scoreboard
  always @(negedge clk) begin
    if (rstN && xferDone) begin
      logic [20:0] it;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 actual=unexpected strobe expected=none");
      end else begin
        it = expQ.pop_front();
        check("R1/R3 addr", memAddr, it[19:0]);
        check("R4 eop", eop, it[20]);
      end
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mCur[i] = 0; mCnt[i] = 0; mBase[i] = 0; mBCnt[i] = 0; mPage[i] = 0; mMode[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check("R9 mask reset", maskOut, 4'hF);
    check("R9 tc reset", tcStatus, 4'h0);
    check("R9 addr reset", memAddr, 20'h0);
    check("R9 eop reset", eop, 1'b0);

    // ch2: single, increment, no autoinit, write, count 2 -> 3 items
    @(posedge clk); #1;
    doLoad(2'd2, 8'h64, 4'h5, 16'h1234, 16'd2);
    grantCh = 2; @(negedge clk);
    check("R9 load clears mask", maskOut[2], 1'b0);
    check("R7 write dir", {memWr, memRd}, 2'b10);
    check("R8 single keepBus", keepBus, 1'b0);
    @(posedge clk); #1;
    repeat (3) doXfer(2'd2, 1'b0);
    @(negedge clk);
    check("R4 tc set", tcStatus[2], 1'b1);
    check("R6 mask set", maskOut[2], 1'b1);
    @(posedge clk); #1;
    doXfer(2'd2, 1'b1);
    @(negedge clk);
    check("R6 masked ignored", memAddr, 20'h51237);

    // ch1: block, decrement, autoinit, read, count 1
    @(posedge clk); #1;
    doLoad(2'd1, 8'h98, 4'hA, 16'h0001, 16'd1);
    grantCh = 1; @(negedge clk);
    check("R7 read dir", {memWr, memRd}, 2'b01);
    check("R8 block keepBus", keepBus, 1'b1);
    @(posedge clk); #1;
    doXfer(2'd1, 1'b0);
    @(negedge clk);
    check("R8 block release at last", keepBus, 1'b0);
    @(posedge clk); #1;
    doXfer(2'd1, 1'b0);
    @(negedge clk);
    check("R5 reload addr", memAddr, 20'hA0001);
    check("R5 mask kept clear", maskOut[1], 1'b0);
    check("R4 tc ch1", tcStatus[1], 1'b1);
    @(posedge clk); #1;
    doLoad(2'd1, 8'h98, 4'hA, 16'h0000, 16'd5);
    doXfer(2'd1, 1'b0);
    @(negedge clk);
    check("R2 wrap down", memAddr, 20'hAFFFF);

    // ch0: demand, increment, verify, wrap up
    @(posedge clk); #1;
    doLoad(2'd0, 8'h20, 4'h3, 16'hFFFF, 16'd2);
    grantCh = 0; dreq = 1; @(negedge clk);
    check("R7 verify no strobe", {memWr, memRd}, 2'b00);
    check("R8 demand keepBus", keepBus, 1'b1);
    @(posedge clk); #1 dreq = 0; @(negedge clk);
    check("R8 demand drop", keepBus, 1'b0);
    @(posedge clk); #1;
    doXfer(2'd0, 1'b0);
    @(negedge clk);
    check("R2 wrap up", memAddr, 20'h30000);
    @(posedge clk); #1;
    doXfer(2'd0, 1'b0);   // count now 0, offset 0x0001

    // R10: load collides with strobe on granted channel at count zero
    loadEn = 1; loadCh = 0; loadMode = 8'h20; loadPage = 4'h3; loadAddr = 16'h4000; loadCount = 16'd7;
    grantCh = 0; xferDone = 1;
    expQ.push_back({1'b0, 4'h3, 16'h0001});
    @(posedge clk); #1 loadEn = 0; xferDone = 0;
    mCur[0] = 16'h4000; mBase[0] = 16'h4000; mCnt[0] = 7; mBCnt[0] = 7;
    @(negedge clk);
    check("R10 load wins addr", memAddr, 20'h34000);
    check("R10 no tc", tcStatus[0], 1'b0);

    // ch3: cascade
    @(posedge clk); #1;
    doLoad(2'd3, 8'hC4, 4'h1, 16'h0100, 16'd0);
    grantCh = 3; @(negedge clk);
    check("R8 cascade no strobe", {memWr, memRd, keepBus}, 3'b000);
    @(posedge clk); #1;
    doXfer(2'd3, 1'b0);
    @(negedge clk);
    check("R8 cascade no step", memAddr, 20'h10100);
    check("R8 cascade no tc", tcStatus[3], 1'b0);

    @(posedge clk); #1;
    check("scoreboard drained", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule